// File: doc/BRIEF.md
# Link-Side PHY Port Controller

This block sits on the link-layer side of a shared interface to a serial-bus physical layer device (the PHY). The two sides share a 2-bit control bus and an 8-bit data bus, both clocked by one system clock. The pins are brought out as separate input, output and output-enable vectors, so the pad ring builds the tristate buffers. Whoever owns the bus decides what a control code means. The PHY owns it by default. The link owns it only after it has won arbitration.

When an enabled transmit FIFO holds data, the block raises its request line for a fixed number of cycles and then waits for the PHY to answer. A grant code followed by an idle code hands the bus to the link. The link then serialises quadlets from the FIFO two bits per clock, sends one idle cycle and releases the pins. A receive code in place of the grant means arbitration was lost. The block then stays off the pins and, once it has no request outstanding, asks again. Independently of arbitration, the block assembles status transfers into decoded fields and assembles received data into quadlets for a receive FIFO.

The arbitration state machine has six states:
- `ST_IDLE` goes to `ST_REQ` when there is data to send.
- `ST_REQ` goes to `ST_WAIT` after the request pulse train.
- `ST_WAIT` goes to `ST_GRANT` on the grant code, or back to `ST_IDLE` on the receive code (lost).
- `ST_GRANT` goes to `ST_SEND` on the idle code when data remains. It goes to `ST_TAIL` if nothing is left, and back to `ST_IDLE` on any other code.
- `ST_SEND` loops while quadlets remain, then goes to `ST_TAIL`.
- `ST_TAIL` goes to `ST_IDLE`.

Soft reset forces `ST_IDLE` from any state.

Top module: `link_phy_port`

## Requirements
- R1: While reset is low, the following outputs are all low: `ctl_oe`, `d_oe`, `lreq`, both FIFO read strobes, `rxq_we`, `stat_valid` and `rx_overflow`.
- R2: `lreq` is raised only when the PHY shows idle (`ctl_in`=00) and a transmit FIFO is non-empty with its enable set. `lreq` goes high in the cycle after that condition is seen and stays high for exactly REQ_LEN (default 3) consecutive cycles.
- R3: When both transmit FIFOs qualify, the asynchronous FIFO is served first. Only `atx_rd` pulses for that grant, and the isochronous data goes out on a later grant.
- R4: After a grant code 11 followed by 00 on `ctl_in`, the link drives `ctl_out`=10 with `ctl_oe`=`d_oe`=1, starting in the cycle after the 00. Each quadlet takes 16 cycles, sent most significant pair first on `d_out[7:6]`, with `d_out[5:0]`=0. The FIFO read strobe pulses once per quadlet, and the link sends further quadlets while the FIFO is non-empty.
- R5: After the last quadlet, the link drives `ctl_out`=00 with the enables high for one cycle, then drops both enables.
- R6: A receive code 10 seen while waiting for a grant means arbitration was lost. The link never raises an enable, and it issues a new request once the PHY shows idle again.
- R7: A status transfer is 8 consecutive cycles of `ctl_in`=01, delivering `d_in[7:6]` most significant pair first. The 16-bit word holds, from bit 15 down: reset_gap, sub_gap, bus_reset, state_timeout, register address (bits 11:8) and register data (bits 7:0). `stat_valid` pulses for one cycle in the cycle after the eighth pair, and the fields hold their value until the next complete transfer.
- R8: With `rx_async_en` or `rx_iso_en` set, 16 consecutive cycles of `ctl_in`=10 build one quadlet, most significant pair first. `rxq_we` pulses for one cycle in the cycle after the sixteenth pair, with the quadlet on `rxq_data`.
- R9: A completed quadlet that meets `rxq_full`=1 is dropped, so `rxq_we` stays low. `rx_overflow` then goes high and stays high.
- R10: `soft_rst` returns the arbiter to idle, releases the pins, stops any request and clears `rx_overflow`.
- R11: Received data is ignored while both receive enables are low. A status transfer or quadlet cut short by a change of control code is discarded, and the next transfer starts fresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared with the PHY |
| rst_n | input | 1 | Active-low hard reset |
| soft_rst | input | 1 | Synchronous soft reset |
| tx_async_en | input | 1 | Enables asynchronous transmit |
| tx_iso_en | input | 1 | Enables isochronous transmit |
| rx_async_en | input | 1 | Enables receive capture |
| rx_iso_en | input | 1 | Enables receive capture |
| atx_empty | input | 1 | Asynchronous transmit FIFO empty |
| atx_data | input | 32 | Asynchronous FIFO head quadlet |
| atx_rd | output | 1 | Asynchronous FIFO pop strobe |
| itx_empty | input | 1 | Isochronous transmit FIFO empty |
| itx_data | input | 32 | Isochronous FIFO head quadlet |
| itx_rd | output | 1 | Isochronous FIFO pop strobe |
| rxq_full | input | 1 | Receive FIFO full |
| rxq_we | output | 1 | Receive FIFO write strobe |
| rxq_data | output | 32 | Received quadlet |
| rx_overflow | output | 1 | Sticky dropped-quadlet flag |
| ctl_in | input | 2 | Control pins as seen from the pads |
| ctl_out | output | 2 | Control code driven by the link |
| ctl_oe | output | 1 | Control pin output enable |
| d_in | input | 8 | Data pins as seen from the pads |
| d_out | output | 8 | Data driven by the link |
| d_oe | output | 1 | Data pin output enable |
| lreq | output | 1 | Bus request line to the PHY |
| stat_valid | output | 1 | Status transfer complete strobe |
| stat_reset_gap | output | 1 | Status reset-gap bit |
| stat_sub_gap | output | 1 | Status subaction-gap bit |
| stat_bus_reset | output | 1 | Status bus-reset bit |
| stat_timeout | output | 1 | Status state-timeout bit |
| stat_reg_addr | output | 4 | Status PHY register address |
| stat_reg_data | output | 8 | Status PHY register data |

## Verification
A state register stuck in or skipping a state shows up at the ports within a cycle or two. Possible signs are a request train of the wrong length, output enables rising without a preceding grant-then-idle pair, or a missing one-cycle idle tail before release. A pair counter that is off by one misaligns every transmitted or received quadlet, so the serialised data no longer equals the FIFO contents after 16 cycles. It also moves `rxq_we` or `stat_valid` off their expected cycle. A receive or status counter that is not cleared when the control code changes corrupts the next complete transfer, and that error is visible in the first word after the interruption.

// File: rtl/lk_pkg.sv
package lk_pkg;

    // Control codes while the PHY owns the control pins
    typedef enum logic [1:0] {
        PC_IDLE    = 2'b00,
        PC_STATUS  = 2'b01,
        PC_RECEIVE = 2'b10,
        PC_GRANT   = 2'b11
    } phy_code_e;

    // Control codes while the link owns the control pins
    typedef enum logic [1:0] {
        LC_IDLE  = 2'b00,
        LC_HOLD  = 2'b01,
        LC_SEND  = 2'b10,
        LC_SPARE = 2'b11
    } link_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_GRANT,
        ST_SEND,
        ST_TAIL
    } arb_state_e;

    // Status word, first field is the most significant bit
    typedef struct packed {
        logic       reset_gap;
        logic       sub_gap;
        logic       bus_reset;
        logic       state_timeout;
        logic [3:0] reg_addr;
        logic [7:0] reg_data;
    } phy_status_t;

endpackage

// File: rtl/lk_lane_deser.sv
module lk_lane_deser #(
    parameter int WORD_W = 32,
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic [LANE_W-1:0] lane,
    output logic              word_done,
    output logic [WORD_W-1:0] word
);
    localparam int NSTEP = WORD_W / LANE_W;
    localparam int CNT_W = $clog2(NSTEP);
    localparam int SH_W  = WORD_W - LANE_W;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NSTEP - 1);

    logic [CNT_W-1:0] cnt;
    logic [SH_W-1:0]  sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            sh        <= '0;
            word      <= '0;
            word_done <= 1'b0;
        end else if (clr) begin
            cnt       <= '0;
            sh        <= '0;
            word      <= '0;
            word_done <= 1'b0;
        end else begin
            word_done <= 1'b0;
            if (shift_en) begin
                if (cnt == LAST) begin
                    word      <= {sh, lane};
                    word_done <= 1'b1;
                    cnt       <= '0;
                end else begin
                    sh  <= {sh[SH_W-LANE_W-1:0], lane};
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;   // interrupted transfer is discarded
            end
        end
    end

    // R8 / R7: a completion strobe never lasts longer than one cycle
    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !word_done);

endmodule

// File: rtl/lk_link_arb.sv
module lk_link_arb
    import lk_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int LANE_W  = 2,
    parameter int QUAD_W  = 32,
    parameter int REQ_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [1:0]        ctl_in,
    input  logic              tx_async_en,
    input  logic              tx_iso_en,
    input  logic              atx_empty,
    input  logic [QUAD_W-1:0] atx_data,
    input  logic              itx_empty,
    input  logic [QUAD_W-1:0] itx_data,
    output logic              lreq,
    output logic              link_owns,
    output logic [1:0]        ctl_out,
    output logic              ctl_oe,
    output logic [DATA_W-1:0] d_out,
    output logic              d_oe,
    output logic              atx_rd,
    output logic              itx_rd
);
    localparam int NPAIR  = QUAD_W / LANE_W;
    localparam int PAIR_W = $clog2(NPAIR);
    localparam int REQ_W  = $clog2(REQ_LEN + 1);
    localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(NPAIR - 1);
    localparam logic [REQ_W-1:0]  LAST_REQ  = REQ_W'(REQ_LEN - 1);

    arb_state_e        state, nxt;
    logic [REQ_W-1:0]  req_cnt;
    logic [PAIR_W-1:0] pair_cnt;
    logic [QUAD_W-1:0] sh;
    logic              use_iso;

    logic a_ok, i_ok, more, load;
    logic [QUAD_W-1:0] head;

    assign a_ok = tx_async_en && !atx_empty;
    assign i_ok = tx_iso_en && !itx_empty;
    assign more = use_iso ? i_ok : a_ok;
    assign head = use_iso ? itx_data : atx_data;
    assign load = !soft_rst &&
                  (((state == ST_GRANT) && (ctl_in == PC_IDLE) && more) ||
                   ((state == ST_SEND) && (pair_cnt == LAST_PAIR) && more));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state <= ST_IDLE;
        else if (soft_rst) state <= ST_IDLE;
        else               state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (ctl_in == PC_IDLE && (a_ok || i_ok)) nxt = ST_REQ;
            ST_REQ:   if (req_cnt == LAST_REQ) nxt = ST_WAIT;
            ST_WAIT: begin
                if (ctl_in == PC_GRANT)        nxt = ST_GRANT;
                else if (ctl_in == PC_RECEIVE) nxt = ST_IDLE;
            end
            ST_GRANT: begin
                if (ctl_in == PC_IDLE) nxt = more ? ST_SEND : ST_TAIL;
                else                   nxt = ST_IDLE;
            end
            ST_SEND:  if (pair_cnt == LAST_PAIR && !more) nxt = ST_TAIL;
            ST_TAIL:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Request counter, source choice and transmit shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_cnt  <= '0;
            pair_cnt <= '0;
            sh       <= '0;
            use_iso  <= 1'b0;
        end else if (soft_rst) begin
            req_cnt  <= '0;
            pair_cnt <= '0;
        end else begin
            if (state == ST_IDLE) begin
                req_cnt <= '0;
                use_iso <= !a_ok;          // asynchronous wins when both qualify
            end else if (state == ST_REQ) begin
                req_cnt <= req_cnt + 1'b1;
            end
            if (load) begin
                sh       <= head;
                pair_cnt <= '0;
            end else if (state == ST_SEND) begin
                sh       <= sh << LANE_W;
                pair_cnt <= pair_cnt + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        lreq      = (state == ST_REQ);
        link_owns = (state == ST_SEND) || (state == ST_TAIL);
        ctl_oe    = link_owns;
        d_oe      = link_owns;
        ctl_out   = (state == ST_SEND) ? LC_SEND : LC_IDLE;
        d_out     = '0;
        if (state == ST_SEND) d_out[DATA_W-1 -: LANE_W] = sh[QUAD_W-1 -: LANE_W];
        atx_rd    = load && !use_iso;
        itx_rd    = load && use_iso;
    end

    // R4: pins are taken only right after the PHY showed idle
    a_r4_take_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_oe) |-> ($past(ctl_in) == PC_IDLE));

    // R5: a normal release is preceded by an idle code from the link
    a_r5_tail_before_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctl_oe) && !$past(soft_rst)) |-> ($past(ctl_out) == LC_IDLE));

    // R2: a request only starts while some enabled FIFO holds data
    a_r2_req_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lreq) |-> $past((tx_async_en && !atx_empty) || (tx_iso_en && !itx_empty)));

    // R3: at most one FIFO is popped at a time
    a_r3_one_reader: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({atx_rd, itx_rd}));

    // R4: a FIFO is never popped while empty
    a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        (atx_rd |-> !atx_empty) and (itx_rd |-> !itx_empty));

endmodule

// File: rtl/link_phy_port.sv
module link_phy_port
    import lk_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int LANE_W  = 2,
    parameter int QUAD_W  = 32,
    parameter int REQ_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              tx_async_en,
    input  logic              tx_iso_en,
    input  logic              rx_async_en,
    input  logic              rx_iso_en,
    input  logic              atx_empty,
    input  logic [QUAD_W-1:0] atx_data,
    output logic              atx_rd,
    input  logic              itx_empty,
    input  logic [QUAD_W-1:0] itx_data,
    output logic              itx_rd,
    input  logic              rxq_full,
    output logic              rxq_we,
    output logic [QUAD_W-1:0] rxq_data,
    output logic              rx_overflow,
    input  logic [1:0]        ctl_in,
    output logic [1:0]        ctl_out,
    output logic              ctl_oe,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] d_out,
    output logic              d_oe,
    output logic              lreq,
    output logic              stat_valid,
    output logic              stat_reset_gap,
    output logic              stat_sub_gap,
    output logic              stat_bus_reset,
    output logic              stat_timeout,
    output logic [3:0]        stat_reg_addr,
    output logic [7:0]        stat_reg_data
);
    localparam int STAT_W = $bits(phy_status_t);

    logic              link_owns;
    logic [LANE_W-1:0] lane;
    logic              rx_shift, st_shift;
    logic              rx_done, st_done;
    logic [QUAD_W-1:0] rx_word;
    logic [STAT_W-1:0] st_word;
    phy_status_t       st;
    logic              unused_lanes;

    assign lane         = d_in[DATA_W-1 -: LANE_W];
    assign unused_lanes = ^d_in[DATA_W-LANE_W-1:0];
    assign rx_shift     = !link_owns && (rx_async_en || rx_iso_en) && (ctl_in == PC_RECEIVE);
    assign st_shift     = !link_owns && (ctl_in == PC_STATUS);

    lk_link_arb #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W),
        .QUAD_W (QUAD_W),
        .REQ_LEN(REQ_LEN)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .ctl_in     (ctl_in),
        .tx_async_en(tx_async_en),
        .tx_iso_en  (tx_iso_en),
        .atx_empty  (atx_empty),
        .atx_data   (atx_data),
        .itx_empty  (itx_empty),
        .itx_data   (itx_data),
        .lreq       (lreq),
        .link_owns  (link_owns),
        .ctl_out    (ctl_out),
        .ctl_oe     (ctl_oe),
        .d_out      (d_out),
        .d_oe       (d_oe),
        .atx_rd     (atx_rd),
        .itx_rd     (itx_rd)
    );

    lk_lane_deser #(.WORD_W(QUAD_W), .LANE_W(LANE_W)) u_rx_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_rst),
        .shift_en (rx_shift),
        .lane     (lane),
        .word_done(rx_done),
        .word     (rx_word)
    );

    lk_lane_deser #(.WORD_W(STAT_W), .LANE_W(LANE_W)) u_st_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_rst),
        .shift_en (st_shift),
        .lane     (lane),
        .word_done(st_done),
        .word     (st_word)
    );

    assign rxq_we   = rx_done && !rxq_full;
    assign rxq_data = rx_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  rx_overflow <= 1'b0;
        else if (soft_rst)           rx_overflow <= 1'b0;
        else if (rx_done && rxq_full) rx_overflow <= 1'b1;
    end

    assign st             = phy_status_t'(st_word);
    assign stat_valid     = st_done;
    assign stat_reset_gap = st.reset_gap;
    assign stat_sub_gap   = st.sub_gap;
    assign stat_bus_reset = st.bus_reset;
    assign stat_timeout   = st.state_timeout;
    assign stat_reg_addr  = st.reg_addr;
    assign stat_reg_data  = st.reg_data;

    // R9: nothing is written into a full receive FIFO
    a_r9_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_we |-> !rxq_full);

    // R9: the overflow flag only clears through soft reset
    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overflow && !soft_rst) |=> rx_overflow);

    // R6: the link never drives the pins while it captures PHY traffic
    a_r6_hands_off: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_shift || st_shift) |-> !(ctl_oe || d_oe));

endmodule

// File: tb/tb_link_phy_port.sv
module tb_link_phy_port;

    logic        clk = 1'b0;
    logic        rst_n, soft_rst;
    logic        tx_async_en, tx_iso_en, rx_async_en, rx_iso_en;
    logic        atx_empty, itx_empty, atx_rd, itx_rd;
    logic [31:0] atx_data, itx_data;
    logic        rxq_full, rxq_we, rx_overflow;
    logic [31:0] rxq_data;
    logic [1:0]  ctl_in, ctl_out;
    logic        ctl_oe, d_oe, lreq;
    logic [7:0]  d_in, d_out;
    logic        stat_valid, stat_reset_gap, stat_sub_gap, stat_bus_reset, stat_timeout;
    logic [3:0]  stat_reg_addr;
    logic [7:0]  stat_reg_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    // Simple FIFO models for the two transmit queues
    logic [31:0] aq [0:15];
    logic [31:0] iq [0:15];
    int a_pop = 0, a_lim = 0, i_pop = 0, i_lim = 0;
    assign atx_data  = aq[a_pop[3:0]];
    assign itx_data  = iq[i_pop[3:0]];
    assign atx_empty = (a_pop >= a_lim);
    assign itx_empty = (i_pop >= i_lim);
    always @(posedge clk) begin
        if (atx_rd) a_pop <= a_pop + 1;
        if (itx_rd) i_pop <= i_pop + 1;
    end

    link_phy_port dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .tx_async_en(tx_async_en), .tx_iso_en(tx_iso_en),
        .rx_async_en(rx_async_en), .rx_iso_en(rx_iso_en),
        .atx_empty(atx_empty), .atx_data(atx_data), .atx_rd(atx_rd),
        .itx_empty(itx_empty), .itx_data(itx_data), .itx_rd(itx_rd),
        .rxq_full(rxq_full), .rxq_we(rxq_we), .rxq_data(rxq_data),
        .rx_overflow(rx_overflow),
        .ctl_in(ctl_in), .ctl_out(ctl_out), .ctl_oe(ctl_oe),
        .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .lreq(lreq),
        .stat_valid(stat_valid), .stat_reset_gap(stat_reset_gap),
        .stat_sub_gap(stat_sub_gap), .stat_bus_reset(stat_bus_reset),
        .stat_timeout(stat_timeout), .stat_reg_addr(stat_reg_addr),
        .stat_reg_data(stat_reg_data)
    );

    // kind (1 = status), receive FIFO full, word
    localparam logic [33:0] VEC [0:5] = '{
        {1'b0, 1'b0, 32'hA5C3_0F96},
        {1'b1, 1'b0, 32'h0000_C3A5},
        {1'b0, 1'b1, 32'h1234_5678},
        {1'b0, 1'b0, 32'hFFFF_0001},
        {1'b1, 1'b0, 32'h0000_2F00},
        {1'b0, 1'b0, 32'h8000_0003}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of PHY pins (called at a falling edge), return at the next falling edge
    task automatic tick(input logic [1:0] c, input logic [1:0] p);
        ctl_in = c;
        d_in   = {p, 6'b0};
        @(negedge clk);
    endtask

    task automatic send_rx(input logic [31:0] w);
        for (int i = 0; i < 16; i++) tick(2'b10, w[31-2*i -: 2]);
    endtask

    task automatic send_stat(input logic [15:0] w);
        for (int i = 0; i < 8; i++) tick(2'b01, w[15-2*i -: 2]);
    endtask

    function automatic logic [15:0] stat_now();
        return {stat_reset_gap, stat_sub_gap, stat_bus_reset, stat_timeout, stat_reg_addr, stat_reg_data};
    endfunction

    // Request, wait, grant, then collect nq quadlets; returns in the tail cycle
    task automatic run_grant(input int nq, output int lreq_n, output logic [63:0] got, output bit shape_ok);
        lreq_n = 0; got = '0; shape_ok = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick(2'b00, 2'b00);
            if (lreq) lreq_n++;
            if (ctl_oe || d_oe) shape_ok = 1'b0;
        end
        tick(2'b11, 2'b00);
        if (ctl_oe || d_oe) shape_ok = 1'b0;
        tick(2'b00, 2'b00);
        for (int i = 0; i < nq * 16; i++) begin
            if (!(ctl_oe && d_oe && ctl_out == 2'b10 && d_out[5:0] == 6'b0)) shape_ok = 1'b0;
            got = {got[61:0], d_out[7:6]};
            tick(2'b00, 2'b00);
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int          lq;
        logic [63:0] got;
        bit          shp, ovf_exp, seen;
        int          a0, i0;

        rst_n = 1'b0; soft_rst = 1'b0;
        tx_async_en = 1'b1; tx_iso_en = 1'b1; rx_async_en = 1'b1; rx_iso_en = 1'b0;
        rxq_full = 1'b0; ctl_in = 2'b00; d_in = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!ctl_oe && !d_oe && !lreq && !atx_rd && !itx_rd && !rxq_we && !stat_valid && !rx_overflow,
            "R1 reset outputs", {24'b0, ctl_oe, d_oe, lreq, atx_rd, itx_rd, rxq_we, stat_valid, rx_overflow}, 32'h0);
        rst_n = 1'b1;
        tick(2'b00, 2'b00);

        // Table of receive / status vectors (R7, R8, R9)
        ovf_exp = 1'b0;
        for (int k = 0; k < 6; k++) begin
            rxq_full = VEC[k][32];
            if (VEC[k][33]) begin
                send_stat(VEC[k][15:0]);
                chk(stat_valid == 1'b1, "R7 status strobe", {31'b0, stat_valid}, 32'h1);
                chk(stat_now() == VEC[k][15:0], "R7 status fields", {16'b0, stat_now()}, {16'b0, VEC[k][15:0]});
                tick(2'b00, 2'b00);
                chk(stat_valid == 1'b0 && stat_now() == VEC[k][15:0], "R7 strobe one cycle, fields held",
                    {15'b0, stat_valid, stat_now()}, {16'b0, VEC[k][15:0]});
            end else begin
                send_rx(VEC[k][31:0]);
                chk(rxq_we == !VEC[k][32], "R8 R9 write strobe", {31'b0, rxq_we}, {31'b0, !VEC[k][32]});
                if (!VEC[k][32]) chk(rxq_data == VEC[k][31:0], "R8 quadlet data", rxq_data, VEC[k][31:0]);
                ovf_exp = ovf_exp | VEC[k][32];
                tick(2'b00, 2'b00);
                chk(rxq_we == 1'b0, "R8 strobe one cycle", {31'b0, rxq_we}, 32'h0);
                chk(rx_overflow == ovf_exp, "R9 sticky overflow", {31'b0, rx_overflow}, {31'b0, ovf_exp});
            end
        end
        rxq_full = 1'b0;

        // R10: soft reset clears overflow
        soft_rst = 1'b1; tick(2'b00, 2'b00); soft_rst = 1'b0;
        chk(rx_overflow == 1'b0, "R10 overflow cleared", {31'b0, rx_overflow}, 32'h0);

        // R11: receive ignored while disabled
        rx_async_en = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 16; i++) begin tick(2'b10, 2'b11); if (rxq_we) seen = 1'b1; end
        tick(2'b00, 2'b00); if (rxq_we) seen = 1'b1;
        chk(!seen, "R11 disabled receive", {31'b0, seen}, 32'h0);
        rx_async_en = 1'b0; rx_iso_en = 1'b1;

        // R11: partial quadlet discarded
        seen = 1'b0;
        for (int i = 0; i < 10; i++) begin tick(2'b10, 2'b01); if (rxq_we) seen = 1'b1; end
        tick(2'b00, 2'b00); if (rxq_we) seen = 1'b1;
        send_rx(32'h3C3C_9669);
        chk(!seen && rxq_we && rxq_data == 32'h3C3C_9669, "R11 partial quadlet dropped", rxq_data, 32'h3C3C_9669);
        tick(2'b00, 2'b00);

        // R11: interrupted status discarded
        seen = 1'b0;
        for (int i = 0; i < 5; i++) begin tick(2'b01, 2'b10); if (stat_valid) seen = 1'b1; end
        tick(2'b00, 2'b00); if (stat_valid) seen = 1'b1;
        send_stat(16'h5A3C);
        chk(!seen && stat_valid && stat_now() == 16'h5A3C, "R11 R7 interrupted status", {16'b0, stat_now()}, 32'h5A3C);
        tick(2'b00, 2'b00);

        // R2: no request while enable is low
        tx_async_en = 1'b0; tx_iso_en = 1'b0;
        aq[a_pop[3:0]] = 32'hC0FF_EE12; aq[(a_pop + 1) % 16] = 32'h5A5A_0F0F;
        a0 = a_pop; a_lim = a_pop + 2;
        seen = 1'b0;
        for (int i = 0; i < 4; i++) begin tick(2'b00, 2'b00); if (lreq) seen = 1'b1; end
        chk(!seen, "R2 no request when disabled", {31'b0, seen}, 32'h0);

        // R2 R4 R5: won arbitration, two quadlets
        tx_async_en = 1'b1; tx_iso_en = 1'b1;
        run_grant(2, lq, got, shp);
        chk(lq == 3, "R2 request length", lq, 3);
        chk(shp, "R4 pin ownership and code", {31'b0, shp}, 32'h1);
        chk(got[63:32] == 32'hC0FF_EE12, "R4 first quadlet", got[63:32], 32'hC0FF_EE12);
        chk(got[31:0] == 32'h5A5A_0F0F, "R4 second quadlet", got[31:0], 32'h5A5A_0F0F);
        chk(a_pop == a0 + 2, "R4 pops", a_pop, a0 + 2);
        chk(ctl_oe && d_oe && ctl_out == 2'b00, "R5 idle tail", {29'b0, ctl_oe, ctl_out}, 32'h4);
        tick(2'b00, 2'b00);
        chk(!ctl_oe && !d_oe, "R5 release", {30'b0, ctl_oe, d_oe}, 32'h0);
        seen = 1'b0;
        for (int i = 0; i < 4; i++) begin tick(2'b00, 2'b00); if (lreq) seen = 1'b1; end
        chk(!seen, "R2 no request when empty", {31'b0, seen}, 32'h0);

        // R6: lost arbitration
        iq[i_pop[3:0]] = 32'h0BAD_F00D; i0 = i_pop; i_lim = i_pop + 1;
        lq = 0; seen = 1'b0;
        for (int i = 0; i < 6; i++) begin tick(2'b00, 2'b00); if (lreq) lq++; if (ctl_oe || d_oe) seen = 1'b1; end
        tick(2'b10, 2'b00); if (ctl_oe || d_oe) seen = 1'b1;
        tick(2'b00, 2'b00); if (ctl_oe || d_oe) seen = 1'b1;
        chk(!seen, "R6 pins stay released", {31'b0, seen}, 32'h0);
        chk(lreq && lq == 3, "R6 new request after loss", {27'b0, lreq, lq[3:0]}, 32'h13);
        chk(i_pop == i0, "R6 nothing popped", i_pop, i0);

        // R10: soft reset stops the request
        soft_rst = 1'b1; i_lim = i_pop; tick(2'b00, 2'b00); soft_rst = 1'b0;
        chk(!lreq && !ctl_oe, "R10 request stopped", {30'b0, lreq, ctl_oe}, 32'h0);
        tick(2'b00, 2'b00);

        // R3: asynchronous served before isochronous
        aq[a_pop[3:0]] = 32'h1111_AAAA; a0 = a_pop; a_lim = a_pop + 1;
        iq[i_pop[3:0]] = 32'h2222_5555; i0 = i_pop; i_lim = i_pop + 1;
        run_grant(1, lq, got, shp);
        chk(shp && got[31:0] == 32'h1111_AAAA, "R3 async first", got[31:0], 32'h1111_AAAA);
        chk(a_pop == a0 + 1 && i_pop == i0, "R3 only async popped", i_pop, i0);
        chk(ctl_oe && ctl_out == 2'b00, "R5 tail after one quadlet", {30'b0, ctl_out}, 32'h0);
        tick(2'b00, 2'b00);
        run_grant(1, lq, got, shp);
        chk(shp && got[31:0] == 32'h2222_5555, "R3 iso on later grant", got[31:0], 32'h2222_5555);
        chk(i_pop == i0 + 1, "R3 iso popped", i_pop, i0 + 1);
        tick(2'b00, 2'b00);
        chk(!ctl_oe && !d_oe, "R5 final release", {30'b0, ctl_oe, d_oe}, 32'h0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule